// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Buffered Compares

This block is a 16-bit dual-slope timer. The counter climbs from zero to a programmable TOP value and then falls back to zero. Each compare channel turns matches between the counter and its compare value into a waveform. Because the counter runs both ways, the pulses stay centred on the bottom of each period. The counter advances only on timer ticks, which a prescaler derives from the system clock with a selectable divisor.

Software writes the TOP value and the compare values into buffers. The active copies load only when the counter sits at zero, so both halves of every period use the same settings. The TOP value can come either from its own buffer or from channel 0's compare value. Each channel has a 2-bit waveform mode and a pin-enable bit. Each channel also has a sticky match flag, and the counter has a sticky bottom flag. Each flag is cleared by a one-cycle strobe.

Top module: `pfcPwmTimer`

## Requirements
- R1: `clkSel` sets the tick divisor N: code 1 gives N=1, 2 gives 8, 3 gives 64, 4 gives 256 and 5 gives 1024. Codes 0, 6 and 7 stop the counter. A free-running 10-bit divider starts at zero on reset, and a tick occurs on the clocks where the divider modulo N equals N-1.
- R2: On each tick the count steps 0,1,…,TOP,TOP-1,…,1,0,1,… and stays at each extreme for one tick. If TOP is 0, the count stays at 0. The period is therefore 2·N·TOP clocks, and `count` changes by at most one per clock.
- R3: Values written to the TOP buffer and to the compare buffers, and the level on `topFromA`, take effect only on a tick where the count is 0. A write in mid-period leaves the current period unchanged.
- R4: Mode 2 (`outMode[2i+1:2i]`=2) gives non-inverted PWM. A match while counting up drives the waveform low, and a match while counting down drives it high. The high time is 2·N·C clocks per period, where C is the compare value.
- R5: Mode 3 gives the complement of mode 2, so the high time is 2·N·(TOP−C) clocks per period.
- R6: In mode 2, a compare value of 0 holds the waveform low and a compare value equal to TOP holds it high. Mode 3 gives the opposite constant levels.
- R7: Mode 1 toggles the waveform on every match. With `topFromA`=1 and channel 0 in mode 1, channel 0 produces a 50% square wave with a period of 4·N·TOP clocks.
- R8: Mode 0 disconnects the waveform, and the pin output is held low.
- R9: `pinOe[i]` follows `dirOut[i]`. When `dirOut[i]` is 0, `pinOut[i]` is held low.
- R10: `cmpFlag[i]` is set by a tick on which the count equals the active compare value. It stays set until a `flagClr[i]` strobe clears it. When a set and a clear coincide, the set wins.
- R11: `ovfFlag` is set by a tick on which the count is 0. It is cleared by an `ovfClr` strobe, and a coinciding set wins.
- R12: When `topFromA`=1 has been loaded at a bottom, TOP is channel 0's active compare value. Otherwise TOP is the separately buffered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSel | input | 3 | Prescaler select code |
| topWrEn | input | 1 | Write strobe for the TOP buffer |
| topWrData | input | 16 | TOP buffer write data |
| topFromA | input | 1 | Take TOP from channel 0 compare (sampled at bottom) |
| cmpWrEn | input | 2 | Per-channel compare buffer write strobe |
| cmpWrData | input | 16 | Compare buffer write data |
| outMode | input | 4 | 2-bit waveform mode per channel |
| dirOut | input | 2 | Per-channel pin output enable |
| flagClr | input | 2 | Per-channel match flag clear strobe |
| ovfClr | input | 1 | Bottom flag clear strobe |
| count | output | 16 | Current counter value |
| pinOut | output | 2 | Gated waveform pins |
| pinOe | output | 2 | Pin driver enables |
| cmpFlag | output | 2 | Sticky compare match flags |
| ovfFlag | output | 1 | Sticky bottom flag |

## Verification
The count, the waveforms and the flags are all registered. Each one shows the effect of a tick one clock edge after the clock in which the tick was active, and the bench reads every output 5 ns after that edge. A buffered write latches at the next edge, but it only reaches the waveform after the next bottom tick, one half-period or more later. The bench therefore checks mid-period writes at counter values reached before and after that bottom. Period and duty are measured over windows that span a whole number of periods once the settings have loaded, so the counts do not depend on where the window starts. The pin enable acts combinationally, so it is checked in the same sample as its input.

// File: rtl/pfcPwmPkg.sv
package pfcPwmPkg;
  localparam int PRE_W = 10;

  typedef struct packed {
    logic tick;
    logic atBottom;
    logic countingUp;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_TOG = 2'd1,
    MODE_NON = 2'd2,
    MODE_INV = 2'd3
  } waveMode_e;

  function automatic logic [PRE_W:0] preMask(input logic [2:0] sel);
    // bit PRE_W is the enable, low bits the divider mask (N-1)
    case (sel)
      3'd1: preMask = {1'b1, 10'd0};
      3'd2: preMask = {1'b1, 10'd7};
      3'd3: preMask = {1'b1, 10'd63};
      3'd4: preMask = {1'b1, 10'd255};
      3'd5: preMask = {1'b1, 10'd1023};
      default: preMask = '0;
    endcase
  endfunction
endpackage

// File: rtl/pfcPwmCtrl.sv
module pfcPwmCtrl
  import pfcPwmPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       clkSel,
  input  logic [CNT_W-1:0] topEff,
  output logic [CNT_W-1:0] cnt,
  output ctlStrobe_t       strobe
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   selMask;
  logic             tick;
  logic             dirUp;

  assign selMask = preMask(clkSel);
  assign tick    = selMask[PRE_W] && ((preCnt & selMask[PRE_W-1:0]) == selMask[PRE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else if (tick) begin
      if (cnt == '0) begin
        if (topEff != '0) begin
          cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
          dirUp <= 1'b1;
        end
      end else if (dirUp && cnt >= topEff) begin
        cnt   <= cnt - 1'b1;
        dirUp <= 1'b0;
      end else if (dirUp) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign strobe.tick       = tick;
  assign strobe.atBottom   = tick && (cnt == '0);
  assign strobe.countingUp = dirUp;
endmodule

// File: rtl/pfcPwmDatapath.sv
module pfcPwmDatapath
  import pfcPwmPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [CNT_W-1:0]      cnt,
  input  logic                  topWrEn,
  input  logic [CNT_W-1:0]      topWrData,
  input  logic                  topFromA,
  input  logic [NUM_CH-1:0]     cmpWrEn,
  input  logic [CNT_W-1:0]      cmpWrData,
  input  logic [2*NUM_CH-1:0]   outMode,
  input  logic [NUM_CH-1:0]     flagClr,
  input  logic                  ovfClr,
  output logic [CNT_W-1:0]      topEff,
  output logic [NUM_CH-1:0]     wave,
  output logic [NUM_CH-1:0]     cmpFlag,
  output logic                  ovfFlag
);
  logic [CNT_W-1:0] topBuf, topAct;
  logic             selAct;
  logic [CNT_W-1:0] cmpActArr [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topBuf <= '0;
      topAct <= '0;
      selAct <= 1'b0;
    end else begin
      if (topWrEn) topBuf <= topWrData;
      if (strobe.atBottom) begin
        topAct <= topBuf;
        selAct <= topFromA;
      end
    end
  end

  assign topEff = selAct ? cmpActArr[0] : topAct;

  always_ff @(posedge clk) begin
    if (!rstN)                 ovfFlag <= 1'b0;
    else if (strobe.atBottom)  ovfFlag <= 1'b1;
    else if (ovfClr)           ovfFlag <= 1'b0;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [CNT_W-1:0] cmpBuf, cmpAct;
    logic             waveR, flagR, hit, level;
    waveMode_e        mode;

    assign mode  = waveMode_e'(outMode[2*g+1:2*g]);
    assign hit   = strobe.tick && (cnt == cmpAct);
    assign level = (cmpAct == '0)     ? 1'b0 :
                   (cmpAct == topEff) ? 1'b1 : !strobe.countingUp;
    assign cmpActArr[g] = cmpAct;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpBuf <= '0;
        cmpAct <= '0;
      end else begin
        if (cmpWrEn[g])      cmpBuf <= cmpWrData;
        if (strobe.atBottom) cmpAct <= cmpBuf;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) waveR <= 1'b0;
      else if (hit) begin
        case (mode)
          MODE_TOG: waveR <= !waveR;
          MODE_NON: waveR <= level;
          MODE_INV: waveR <= !level;
          default:  waveR <= waveR;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)         flagR <= 1'b0;
      else if (hit)      flagR <= 1'b1;
      else if (flagClr[g]) flagR <= 1'b0;
    end

    assign wave[g]    = (mode == MODE_OFF) ? 1'b0 : waveR;
    assign cmpFlag[g] = flagR;
  end
endmodule

// File: rtl/pfcPwmTimer.sv
module pfcPwmTimer
  import pfcPwmPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          clkSel,
  input  logic                topWrEn,
  input  logic [CNT_W-1:0]    topWrData,
  input  logic                topFromA,
  input  logic [NUM_CH-1:0]   cmpWrEn,
  input  logic [CNT_W-1:0]    cmpWrData,
  input  logic [2*NUM_CH-1:0] outMode,
  input  logic [NUM_CH-1:0]   dirOut,
  input  logic [NUM_CH-1:0]   flagClr,
  input  logic                ovfClr,
  output logic [CNT_W-1:0]    count,
  output logic [NUM_CH-1:0]   pinOut,
  output logic [NUM_CH-1:0]   pinOe,
  output logic [NUM_CH-1:0]   cmpFlag,
  output logic                ovfFlag
);
  ctlStrobe_t        strobe;
  logic [CNT_W-1:0]  topEff;
  logic [NUM_CH-1:0] wave;

  pfcPwmCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .topEff(topEff),
    .cnt(count), .strobe(strobe)
  );

  pfcPwmDatapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(count),
    .topWrEn(topWrEn), .topWrData(topWrData), .topFromA(topFromA),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .outMode(outMode),
    .flagClr(flagClr), .ovfClr(ovfClr), .topEff(topEff),
    .wave(wave), .cmpFlag(cmpFlag), .ovfFlag(ovfFlag)
  );

  assign pinOe  = dirOut;
  assign pinOut = wave & dirOut;
endmodule

// File: rtl/pfcPwmChecker.sv
module pfcPwmChecker #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        clkSel,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  topEff,
  input logic [NUM_CH-1:0] cmpFlag,
  input logic [NUM_CH-1:0] flagClr,
  input logic              ovfFlag
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0 || clkSel > 3'd5) |=> $stable(count)); // R1

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    count <= topEff); // R2

  AST_CNT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(count) |-> (count == $past(count) + 1'b1 || count == $past(count) - 1'b1)); // R2

  AST_TOP_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(topEff) |-> $past(count) == '0); // R3

  AST_OVF_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(count) == '0); // R11

  for (genvar g = 0; g < NUM_CH; g++) begin : gAst
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (cmpFlag[g] && !flagClr[g]) |=> cmpFlag[g]); // R10
  end
endmodule

bind pfcPwmTimer pfcPwmChecker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .clkSel(clkSel), .count(count), .topEff(topEff),
  .cmpFlag(cmpFlag), .flagClr(flagClr), .ovfFlag(ovfFlag)
);

// File: tb/test_pfcPwmTimer.sv
module test_pfcPwmTimer;
  logic        clk = 0;
  logic        rstN = 0;
  logic [2:0]  clkSel = 0;
  logic        topWrEn = 0;
  logic [15:0] topWrData = 0;
  logic        topFromA = 0;
  logic [1:0]  cmpWrEn = 0;
  logic [15:0] cmpWrData = 0;
  logic [3:0]  outMode = 0;
  logic [1:0]  dirOut = 0;
  logic [1:0]  flagClr = 0;
  logic        ovfClr = 0;
  logic [15:0] count;
  logic [1:0]  pinOut, pinOe, cmpFlag;
  logic        ovfFlag;

  int nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  pfcPwmTimer i_pfcPwmTimer (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .topWrEn(topWrEn),
    .topWrData(topWrData), .topFromA(topFromA), .cmpWrEn(cmpWrEn),
    .cmpWrData(cmpWrData), .outMode(outMode), .dirOut(dirOut),
    .flagClr(flagClr), .ovfClr(ovfClr), .count(count), .pinOut(pinOut),
    .pinOe(pinOe), .cmpFlag(cmpFlag), .ovfFlag(ovfFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mPc, mCnt, mTopBuf, mTopAct;
  bit mUp, mSelAct, mOvf;
  int mCmpBuf[2], mCmpAct[2];
  bit mW[2], mFlag[2];

  function automatic int divOf(input logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPc = 0; mCnt = 0; mTopBuf = 0; mTopAct = 0; mUp = 1; mSelAct = 0; mOvf = 0;
      for (int c = 0; c < 2; c++) begin mCmpBuf[c] = 0; mCmpAct[c] = 0; mW[c] = 0; mFlag[c] = 0; end
    end else begin
      int n, topE, md, oldCnt;
      bit tk, lvl;
      bit setF[2];
      n = divOf(clkSel);
      tk = (n != 0) && ((mPc % n) == n - 1);
      mPc = (mPc + 1) % 1024;
      setF[0] = 0; setF[1] = 0;
      if (tk) begin
        topE = mSelAct ? mCmpAct[0] : mTopAct;
        oldCnt = mCnt;
        for (int c = 0; c < 2; c++) begin
          if (mCnt == mCmpAct[c]) begin
            setF[c] = 1;
            md = outMode[2*c +: 2];
            if (mCmpAct[c] == 0) lvl = 0;
            else if (mCmpAct[c] == topE) lvl = 1;
            else lvl = !mUp;
            if (md == 1) mW[c] = !mW[c];
            else if (md == 2) mW[c] = lvl;
            else if (md == 3) mW[c] = !lvl;
          end
        end
        if (mCnt == 0) begin
          if (topE != 0) begin mCnt = 1; mUp = 1; end
        end else if (mUp && mCnt >= topE) begin mCnt--; mUp = 0; end
        else if (mUp) mCnt++;
        else mCnt--;
        if (oldCnt == 0) begin
          mOvf = 1;
          mTopAct = mTopBuf; mSelAct = topFromA;
          mCmpAct[0] = mCmpBuf[0]; mCmpAct[1] = mCmpBuf[1];
        end else if (ovfClr) mOvf = 0;
      end else if (ovfClr) mOvf = 0;
      for (int c = 0; c < 2; c++) begin
        if (setF[c]) mFlag[c] = 1;
        else if (flagClr[c]) mFlag[c] = 0;
        if (cmpWrEn[c]) mCmpBuf[c] = cmpWrData;
      end
      if (topWrEn) mTopBuf = topWrData;
    end
  end

  // per-clock comparison, 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      chk(count == mCnt[15:0], "R2 count", count, mCnt);
      for (int c = 0; c < 2; c++) begin
        bit ep;
        ep = dirOut[c] && (outMode[2*c +: 2] != 0) && mW[c];
        chk(pinOut[c] == ep, "R4 pinOut", pinOut[c], ep);
        chk(pinOe[c] == dirOut[c], "R9 pinOe", pinOe[c], dirOut[c]);
        chk(cmpFlag[c] == mFlag[c], "R10 cmpFlag", cmpFlag[c], mFlag[c]);
      end
      chk(ovfFlag == mOvf, "R11 ovfFlag", ovfFlag, mOvf);
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 0; clkSel = 0; topWrEn = 0; cmpWrEn = 0; flagClr = 0; ovfClr = 0;
    topFromA = 0; outMode = 0; dirOut = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic wrCmp(input int c, input int v);
    @(negedge clk); cmpWrEn[c] = 1; cmpWrData = v[15:0];
    @(negedge clk); cmpWrEn[c] = 0;
  endtask

  task automatic wrTop(input int v);
    @(negedge clk); topWrEn = 1; topWrData = v[15:0];
    @(negedge clk); topWrEn = 0;
  endtask

  task automatic setup(input int sel, input int top, input int ca, input int cb,
                       input int ma, input int mb, input bit fromA);
    doReset();
    clkSel = sel[2:0]; outMode = {mb[1:0], ma[1:0]}; dirOut = 2'b11; topFromA = fromA;
    wrCmp(0, ca); wrCmp(1, cb); wrTop(top);
  endtask

  task automatic measure(input int c, input int clocks, output int highs, output int rises);
    bit prev;
    highs = 0; rises = 0;
    @(posedge clk); #5; prev = pinOut[c];
    for (int k = 0; k < clocks; k++) begin
      @(posedge clk); #5;
      if (pinOut[c]) highs++;
      if (pinOut[c] && !prev) rises++;
      prev = pinOut[c];
    end
  endtask

  task automatic waitCnt(input int v, input int pv);
    int last;
    last = -1;
    forever begin
      @(posedge clk); #5;
      if (count == v[15:0] && last == pv) break;
      last = count;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int h, r;
    doReset();
    @(posedge clk); #5;
    chk(count == 0, "R2 reset count", count, 0);
    chk(pinOut == 0, "R9 reset pins", pinOut, 0);
    chk(cmpFlag == 0, "R10 reset flags", cmpFlag, 0);

    // N=1, TOP=10: non-inverted C=3, inverted C=7
    setup(1, 10, 3, 7, 2, 3, 0);
    repeat (60) @(negedge clk);
    measure(0, 60, h, r);
    chk(h == 18, "R4 high time N=1", h, 18);
    chk(r == 3, "R2 period N=1", r, 3);
    measure(1, 60, h, r);
    chk(h == 18, "R5 inverted high time", h, 18);

    // R10 clear then re-set
    waitCnt(9, 8);
    @(negedge clk); flagClr[0] = 1; @(negedge clk); flagClr[0] = 0;
    #6; chk(cmpFlag[0] == 0, "R10 flag cleared", cmpFlag[0], 0);
    waitCnt(2, 3);
    chk(cmpFlag[0] == 1, "R10 flag set on match", cmpFlag[0], 1);
    // R11 clear then re-set
    waitCnt(5, 4);
    @(negedge clk); ovfClr = 1; @(negedge clk); ovfClr = 0;
    #6; chk(ovfFlag == 0, "R11 ovf cleared", ovfFlag, 0);
    waitCnt(1, 0);
    chk(ovfFlag == 1, "R11 ovf set at bottom", ovfFlag, 1);

    // R3 mid-period compare write waits for bottom
    waitCnt(8, 7);
    wrCmp(0, 9);
    waitCnt(5, 6);
    chk(pinOut[0] == 0, "R3 old compare kept", pinOut[0], 0);
    waitCnt(5, 4);
    chk(pinOut[0] == 1, "R3 new compare after bottom", pinOut[0], 1);

    // R1 stopped prescaler freezes count
    begin
      int held;
      @(negedge clk); clkSel = 0;
      @(posedge clk); #5; held = count;
      repeat (50) @(posedge clk);
      #5; chk(count == held[15:0], "R1 stopped", count, held);
    end

    // N=8, TOP=20
    setup(2, 20, 5, 15, 2, 3, 0);
    repeat (700) @(negedge clk);
    measure(0, 640, h, r);
    chk(h == 160, "R4 high time N=8", h, 160);
    chk(r == 2, "R1 period N=8", r, 2);
    measure(1, 640, h, r);
    chk(h == 160, "R5 inverted N=8", h, 160);

    // N=64, TOP=6, C=2
    setup(3, 6, 2, 2, 2, 2, 0);
    repeat (1600) @(negedge clk);
    measure(0, 768, h, r);
    chk(h == 256, "R1 high time N=64", h, 256);
    chk(r == 1, "R1 period N=64", r, 1);

    // N=256, TOP=3, C=1
    setup(4, 3, 1, 1, 2, 2, 0);
    repeat (3200) @(negedge clk);
    measure(0, 1536, h, r);
    chk(h == 512, "R1 high time N=256", h, 512);

    // N=1024, TOP=2, C=1
    setup(5, 2, 1, 1, 2, 2, 0);
    repeat (8400) @(negedge clk);
    measure(0, 4096, h, r);
    chk(h == 2048, "R1 high time N=1024", h, 2048);
    chk(r == 1, "R1 period N=1024", r, 1);

    // R6 extremes, non-inverted then inverted; N=8, TOP=5
    setup(2, 5, 0, 5, 2, 2, 0);
    repeat (200) @(negedge clk);
    measure(0, 160, h, r);
    chk(h == 0, "R6 C=0 stays low", h, 0);
    measure(1, 160, h, r);
    chk(h == 160, "R6 C=TOP stays high", h, 160);
    setup(2, 5, 0, 5, 3, 3, 0);
    repeat (200) @(negedge clk);
    measure(0, 160, h, r);
    chk(h == 160, "R6 inverted C=0 stays high", h, 160);
    measure(1, 160, h, r);
    chk(h == 0, "R6 inverted C=TOP stays low", h, 0);

    // R7/R12 TOP from channel 0, toggle mode, N=1, TOP=12
    setup(1, 99, 12, 4, 1, 2, 1);
    repeat (100) @(negedge clk);
    measure(0, 96, h, r);
    chk(h == 48, "R7 toggle 50% duty", h, 48);
    chk(r == 2, "R7 toggle period 4*N*TOP", r, 2);
    measure(1, 96, h, r);
    chk(h == 32, "R12 TOP taken from channel 0", h, 32);

    // R8 mode off, R9 pin disabled
    @(negedge clk); outMode = 4'b1000; dirOut = 2'b01;
    measure(0, 96, h, r);
    chk(h == 0, "R8 mode off pin low", h, 0);
    measure(1, 96, h, r);
    chk(h == 0, "R9 disabled pin low", h, 0);
    chk(pinOe == 2'b01, "R9 pinOe follows dirOut", pinOe, 1);

    finishRun();
  end
endmodule